// File: doc/BRIEF.md
# Compound Branch Condition Evaluator

This block decides, one cycle after a request, whether a conditional jump is taken. It compares two register operands, picks one status flag out of the flag register, and merges the comparison with the flag in one of four ways. A 6-bit extension field controls all three choices.

The caller supplies the operand values and their register indices. It also supplies the flag register, the word that follows the branch instruction (the target), and that word's address. The block returns a taken indication and the next program-counter value. That value is the target when the branch is taken, and the address just past the target word when it is not. Register reads and the program-counter register itself live outside the block. All comparisons are unsigned.

Top module: `br_cond_eval`

## Requirements
- R1: While reset is asserted and after its release, `res_valid`, `br_taken` and `pc_value` read zero until the first accepted request.
- R2: `res_valid` is high exactly in the cycle after a cycle with `eval_valid` high. `br_taken` and `pc_value` for a request appear in that same cycle.
- R3: `ext[1:0]` selects the comparison of `opnd_a` against `opnd_b`. Code 0 is equal, 1 is not equal, 2 is unsigned less than, and 3 is unsigned less than or equal.
- R4: With comparison code 0, the equality test is true whenever `idx_a` equals `idx_b`, whatever the operand data. Code 1 still compares the data.
- R5: `ext[3:2]` selects a flag bit. Code 0 is overflow (`flags[0]`), 1 is zero (`flags[1]`), 2 is sign (`flags[2]`) and 3 is parity (`flags[3]`). No other bit of `flags` affects the result.
- R6: `ext[5:4]` selects the merge of comparison c and flag f. Code 0 gives c, 1 gives c OR f, 2 gives c AND NOT f, and 3 gives c OR NOT f.
- R7: When the branch is taken, `pc_value` equals the `target_word` of that request.
- R8: When the branch is not taken, `pc_value` equals `word_addr + 1`, wrapping modulo 2^32.
- R9: In a cycle after one with `eval_valid` low, `br_taken` and `pc_value` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_valid | input | 1 | Request strobe; inputs are sampled when high |
| ext | input | 6 | Condition control: compare, flag, merge |
| idx_a | input | 5 | Register index of first operand |
| idx_b | input | 5 | Register index of second operand |
| opnd_a | input | 32 | First operand value |
| opnd_b | input | 32 | Second operand value |
| flags | input | 32 | Status flag register |
| target_word | input | 32 | Word following the branch instruction |
| word_addr | input | 32 | Address of that following word |
| res_valid | output | 1 | Result strobe, one cycle after request |
| br_taken | output | 1 | Branch decision |
| pc_value | output | 32 | Value to load into the program counter |

## Verification
Each comparison code is tried with operand pairs that are equal, just below and just above each other. The pairs include all-ones against one, which separates unsigned from signed ordering. Pairs with identical indices but different data show that only the equality code is forced, while not-equal still looks at the data. For each merge mode the comparison is held false or true so that the selected flag alone sets the outcome. Flag words with every other bit set show that only the chosen bit counts. The taken and not-taken outcomes each check the program-counter value, including an address that wraps at the top of the range.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam int EXT_W = 6;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_NE = 2'd1,
    CMP_LT = 2'd2,
    CMP_LE = 2'd3
  } cmp_sel_e;

  typedef enum logic [1:0] {
    MRG_CMP     = 2'd0,
    MRG_OR      = 2'd1,
    MRG_AND_NOT = 2'd2,
    MRG_OR_NOT  = 2'd3
  } mrg_sel_e;

  // unsigned comparison; equality forced when both indices name one register
  function automatic logic cmp_eval(cmp_sel_e sel, logic [31:0] a,
                                    logic [31:0] b, logic same_reg);
    case (sel)
      CMP_EQ:  return same_reg || (a == b);
      CMP_NE:  return a != b;
      CMP_LT:  return a < b;
      default: return a <= b;
    endcase
  endfunction

  function automatic logic merge_eval(mrg_sel_e sel, logic c, logic f);
    case (sel)
      MRG_CMP:     return c;
      MRG_OR:      return c | f;
      MRG_AND_NOT: return c & ~f;
      default:     return c | ~f;
    endcase
  endfunction
endpackage

// File: rtl/br_cmp_unit.sv
module br_cmp_unit
  import br_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic [1:0]        sel,
  input  logic [IDX_W-1:0]  idx_a,
  input  logic [IDX_W-1:0]  idx_b,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              hit
);
  logic        same_reg;
  logic [31:0] a_x, b_x;

  assign same_reg = (idx_a == idx_b);

  generate
    if (DATA_W >= 32) begin : g_trunc
      assign a_x = a[31:0];
      assign b_x = b[31:0];
    end else begin : g_zext
      assign a_x = {{(32-DATA_W){1'b0}}, a};
      assign b_x = {{(32-DATA_W){1'b0}}, b};
    end
  endgenerate

  assign hit = cmp_eval(cmp_sel_e'(sel), a_x, b_x, same_reg);
endmodule

// File: rtl/br_flag_pick.sv
module br_flag_pick #(
  parameter int FLAG_W = 32,
  parameter int N_SEL  = 4
) (
  input  logic [FLAG_W-1:0]        flags,
  input  logic [$clog2(N_SEL)-1:0] sel,
  output logic                     bit_out
);
  logic [N_SEL-1:0] cand;

  genvar gi;
  generate
    for (gi = 0; gi < N_SEL; gi++) begin : g_cand
      assign cand[gi] = flags[gi];
    end
  endgenerate

  assign bit_out = cand[sel];
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  parameter int FLAG_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_valid,
  input  logic [5:0]        ext,
  input  logic [IDX_W-1:0]  idx_a,
  input  logic [IDX_W-1:0]  idx_b,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [FLAG_W-1:0] flags,
  input  logic [ADDR_W-1:0] target_word,
  input  logic [ADDR_W-1:0] word_addr,
  output logic              res_valid,
  output logic              br_taken,
  output logic [ADDR_W-1:0] pc_value
);
  localparam int FLAG_SEL_N = 4;

  logic              cmp_hit;
  logic              flag_bit;
  logic              take_now;
  logic [ADDR_W-1:0] fall_through;

  br_cmp_unit #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_cmp (
    .sel   (ext[1:0]),
    .idx_a (idx_a),
    .idx_b (idx_b),
    .a     (opnd_a),
    .b     (opnd_b),
    .hit   (cmp_hit)
  );

  br_flag_pick #(.FLAG_W(FLAG_W), .N_SEL(FLAG_SEL_N)) u_flag (
    .flags   (flags),
    .sel     (ext[3:2]),
    .bit_out (flag_bit)
  );

  assign take_now     = merge_eval(mrg_sel_e'(ext[5:4]), cmp_hit, flag_bit);
  assign fall_through = word_addr + ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      br_taken  <= 1'b0;
      pc_value  <= '0;
    end else begin
      res_valid <= eval_valid;
      if (eval_valid) begin
        br_taken <= take_now;
        pc_value <= take_now ? target_word : fall_through;
      end
    end
  end

  // R2
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> res_valid == $past(eval_valid));
  // R4
  a_r4_same_index_eq: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_valid && ext[1:0] == 2'd0 && idx_a == idx_b) |-> cmp_hit);
  // R6
  a_r6_and_not_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_valid && ext[5:4] == 2'd2 && flag_bit) |=> !br_taken);
  // R7
  a_r7_taken_target: assert property (@(posedge clk) disable iff (!rst_n)
    eval_valid |=> (!br_taken || pc_value == $past(target_word)));
  // R8
  a_r8_not_taken_step: assert property (@(posedge clk) disable iff (!rst_n)
    eval_valid |=> (br_taken || pc_value == $past(word_addr) + ADDR_W'(1)));
  // R9
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_valid |=> ($stable(br_taken) && $stable(pc_value)));
endmodule

// File: tb/sim_br_cond_eval.sv
module sim_br_cond_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eval_valid = 1'b0;
  logic [5:0]  ext = '0;
  logic [4:0]  idx_a = '0, idx_b = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0, flags = '0;
  logic [31:0] target_word = '0, word_addr = '0;
  logic        res_valid, br_taken;
  logic [31:0] pc_value;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  br_cond_eval u0 (
    .clk(clk), .rst_n(rst_n), .eval_valid(eval_valid), .ext(ext),
    .idx_a(idx_a), .idx_b(idx_b), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .flags(flags), .target_word(target_word), .word_addr(word_addr),
    .res_valid(res_valid), .br_taken(br_taken), .pc_value(pc_value)
  );

  typedef struct packed {
    logic [5:0]  ext;
    logic [4:0]  ia;
    logic [4:0]  ib;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] fl;
    logic        take;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{6'h00, 5'd1, 5'd2, 32'd5,          32'd5,          32'h0,        1'b1}, // R3 eq
    '{6'h00, 5'd1, 5'd2, 32'd5,          32'd6,          32'h0,        1'b0}, // R3 eq miss
    '{6'h00, 5'd3, 5'd3, 32'd5,          32'd6,          32'h0,        1'b1}, // R4 forced
    '{6'h01, 5'd3, 5'd3, 32'd5,          32'd6,          32'h0,        1'b1}, // R4 ne uses data
    '{6'h01, 5'd1, 5'd2, 32'd7,          32'd7,          32'h0,        1'b0}, // R3 ne
    '{6'h02, 5'd1, 5'd2, 32'hFFFF_FFFF,  32'd1,          32'h0,        1'b0}, // R3 lt unsigned
    '{6'h02, 5'd1, 5'd2, 32'd1,          32'hFFFF_FFFF,  32'h0,        1'b1}, // R3 lt
    '{6'h03, 5'd1, 5'd2, 32'd9,          32'd9,          32'h0,        1'b1}, // R3 le equal
    '{6'h03, 5'd1, 5'd2, 32'd10,         32'd9,          32'h0,        1'b0}, // R3 le above
    '{6'h14, 5'd1, 5'd2, 32'd1,          32'd2,          32'h2,        1'b1}, // R6 or, zero flag
    '{6'h14, 5'd1, 5'd2, 32'd1,          32'd2,          32'hFFFF_FFFD, 1'b0}, // R5 others ignored
    '{6'h28, 5'd1, 5'd2, 32'd4,          32'd4,          32'h4,        1'b0}, // R6 and-not, sign
    '{6'h28, 5'd1, 5'd2, 32'd4,          32'd4,          32'h0,        1'b1}, // R6 and-not clear
    '{6'h3C, 5'd1, 5'd2, 32'd1,          32'd2,          32'h8,        1'b0}, // R6 or-not, parity
    '{6'h3C, 5'd1, 5'd2, 32'd1,          32'd2,          32'h0,        1'b1}, // R6 or-not clear
    '{6'h10, 5'd1, 5'd2, 32'd1,          32'd2,          32'h1,        1'b1}, // R5 overflow bit
    '{6'h10, 5'd1, 5'd2, 32'd1,          32'd2,          32'hE,        1'b0}  // R5 overflow clear
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input vec_t v, input logic [31:0] tw, input logic [31:0] wa);
    @(negedge clk);
    ext = v.ext; idx_a = v.ia; idx_b = v.ib;
    opnd_a = v.a; opnd_b = v.b; flags = v.fl;
    target_word = tw; word_addr = wa;
    eval_valid = 1'b1;
    @(negedge clk);
    eval_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] keep_pc;
    logic        keep_tk;
    repeat (3) @(negedge clk);
    check("R1 valid", {31'd0, res_valid}, 32'd0);
    check("R1 taken", {31'd0, br_taken}, 32'd0);
    check("R1 pc", pc_value, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after release", {31'd0, res_valid}, 32'd0);
    check("R1 pc after release", pc_value, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] tw, wa, exp_pc;
      tw = 32'h1000 + i;
      wa = 32'h200 + 3 * i;
      exp_pc = TBL[i].take ? tw : wa + 1;
      issue(TBL[i], tw, wa);
      check($sformatf("R2 valid v%0d", i), {31'd0, res_valid}, 32'd1);
      check($sformatf("R3/R4/R5/R6 taken v%0d", i), {31'd0, br_taken}, {31'd0, TBL[i].take});
      check($sformatf("%s pc v%0d", TBL[i].take ? "R7" : "R8", i), pc_value, exp_pc);
    end

    // R2: valid drops one cycle after the request ended
    @(negedge clk);
    check("R2 valid low", {31'd0, res_valid}, 32'd0);

    // R8: fall-through wraps at top of address range
    issue('{6'h00, 5'd1, 5'd2, 32'd1, 32'd2, 32'h0, 1'b0}, 32'hABCD_0000, 32'hFFFF_FFFF);
    check("R8 wrap pc", pc_value, 32'h0);

    // R7: taken, pc from target word
    issue('{6'h00, 5'd4, 5'd4, 32'd1, 32'd2, 32'h0, 1'b1}, 32'hCAFE_0001, 32'h10);
    check("R7 taken", {31'd0, br_taken}, 32'd1);
    check("R7 pc", pc_value, 32'hCAFE_0001);

    // R9: inputs change while idle, outputs hold
    keep_pc = pc_value; keep_tk = br_taken;
    @(negedge clk);
    ext = 6'h01; idx_a = 5'd1; idx_b = 5'd2; opnd_a = 32'd3; opnd_b = 32'd3;
    target_word = 32'h5555; word_addr = 32'h7777;
    repeat (2) @(negedge clk);
    check("R9 taken held", {31'd0, br_taken}, {31'd0, keep_tk});
    check("R9 pc held", pc_value, keep_pc);
    check("R9 valid low", {31'd0, res_valid}, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule